// File: doc/BRIEF.md
# Multi-Mode Iterative Divider

This unit divides a 32-bit or 16-bit dividend by a 16-bit divisor, producing one quotient bit per step. One datapath covers five operation kinds: signed and unsigned 32-by-16 integer division, signed and unsigned 16-by-16 integer division, and a signed fractional 16-by-16 division on Q1.15 operands. Every operation uses the same sequence of 18 steps. The first step widens the stored operand to 32 bits and takes magnitudes. Sixteen restoring steps follow, and a last step applies sign correction and range checks.

A pulse on `start` while the unit is idle captures the mode and operands. Each later clock edge with `step_en` high advances the sequence by one step, and a low `step_en` freezes it. This lets an outside sequencer pause and resume a divide. When the final step is taken, `done` pulses for one cycle and the results appear on `quotient`, `remainder` and `overflow`. They hold until the next completion.

The controller moves through these states. IDLE goes to EXTEND on `start`. EXTEND goes to DIVIDE on `step_en`. DIVIDE repeats for 16 enabled edges and then goes to FIXUP. FIXUP goes to DONE on `step_en`. DONE returns to IDLE on the next edge with no condition.

Top module: `iter_divider`

## Requirements
- R1: With `mode`=0, the dividend is the two's-complement value {`dividend_hi`,`dividend_lo`} and the divisor is signed. The quotient is the true quotient truncated toward zero.
- R2: With `mode`=1, both the dividend {`dividend_hi`,`dividend_lo`} and the divisor are unsigned, and the quotient is the floor of their ratio.
- R3: With `mode`=2, the dividend is `dividend_lo` sign-extended. With `mode`=3, it is `dividend_lo` zero-extended, and `mode` codes 5 to 7 act like 3. In these modes `dividend_hi` has no effect on any output.
- R4: With `mode`=4, both operands are Q1.15. The quotient is the truncation toward zero of (signed `dividend_lo` × 32768) / signed `divisor`.
- R5: When `overflow` is low, `remainder` equals dividend − quotient × divisor. Its magnitude is below that of the divisor, and it carries the sign of the dividend (or is zero).
- R6: With `step_en` held high, `done` is high in the cycle that follows the 18th clock edge after the edge that sampled `start`. The whole operation therefore spans 19 cycles.
- R7: A clock edge with `step_en` low does not advance the sequence. `done` arrives only after exactly 18 enabled edges following the start edge.
- R8: `busy` is high from the start edge until `done` rises and is low while `done` is high. `done` lasts exactly one cycle.
- R9: A `start` pulse while the unit is not idle is ignored. The running operation completes with its original operands.
- R10: A divisor of zero sets `overflow`. `quotient` and `remainder` are then unspecified.
- R11: A quotient outside the 16-bit range of the mode sets `overflow`. The signed range is −32768 to 32767 and the unsigned range is 0 to 65535.
- R12: After reset, `quotient`, `remainder`, `overflow`, `busy` and `done` are 0. The result outputs change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a divide (taken only when idle) |
| step_en | input | 1 | Enables one step on this edge |
| mode | input | 3 | Operation kind, codes per R1 to R4 |
| dividend_hi | input | 16 | Upper dividend word (32/16 modes) |
| dividend_lo | input | 16 | Lower dividend word, or the whole 16-bit dividend |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Divide by zero or quotient out of range |

## Verification
The hardest case to reach is a divide whose step sequence is broken up by many pauses of unequal length while other inputs keep changing. A duplicate `start` may arrive in the middle of it. The stimulus draws a fresh pause probability for each operation and drives `step_en` at random on every cycle. It changes the operand inputs right after the start edge and injects a second `start` partway through some operations. It then checks that the number of enabled edges is exactly 18 and that the results belong to the first operand set. Directed cases cover the range edges that random values seldom hit. These are the most negative dividend divided by −1, quotients of exactly −32768 and 32768, zero dividends, divisors of ±1 and zero, and fractional operands of equal magnitude.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [2:0] {
        MD_S32  = 3'd0,
        MD_U32  = 3'd1,
        MD_S16  = 3'd2,
        MD_U16  = 3'd3,
        MD_FRAC = 3'd4
    } div_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXTEND,
        ST_DIVIDE,
        ST_FIXUP,
        ST_DONE
    } div_state_e;

endpackage

// File: rtl/div_fsm.sv
module div_fsm
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       step_en_i,
    output div_state_e state_o,
    output logic       accept_o,
    output logic       ext_en_o,
    output logic       div_en_o,
    output logic       fix_en_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int CW        = $clog2(W);
    localparam int TOTAL_STP = W + 2;

    div_state_e     st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_EXTEND;
            ST_EXTEND: if (step_en_i) begin
                           st_d  = ST_DIVIDE;
                           cnt_d = '0;
                       end
            ST_DIVIDE: if (step_en_i) begin
                           if (cnt_q == CW'(W - 1)) st_d = ST_FIXUP;
                           else                     cnt_d = cnt_q + 1'b1;
                       end
            ST_FIXUP:  if (step_en_i) st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        accept_o = (st_q == ST_IDLE) && start_i;
        ext_en_o = (st_q == ST_EXTEND) && step_en_i;
        div_en_o = (st_q == ST_DIVIDE) && step_en_i;
        fix_en_o = (st_q == ST_FIXUP) && step_en_i;
        busy_o   = (st_q == ST_EXTEND) || (st_q == ST_DIVIDE) || (st_q == ST_FIXUP);
        done_o   = (st_q == ST_DONE);
        state_o  = st_q;
    end

    // checker counter: enabled edges since the accepting edge
    logic [7:0] chk_steps_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   chk_steps_q <= '0;
        else if (accept_o)            chk_steps_q <= '0;
        else if (busy_o && step_en_i) chk_steps_q <= chk_steps_q + 1'b1;
    end

    AST_STEP_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> chk_steps_q == 8'(TOTAL_STP));                              // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                   // R8
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);                                                   // R8
    AST_PAUSE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !step_en_i |=> $stable(st_q) && $stable(cnt_q));             // R7

endmodule

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   mode_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dsr_i,
    output logic [W-1:0] mag_hi_o,
    output logic [W-1:0] mag_lo_o,
    output logic [W-1:0] dmag_o,
    output logic         qneg_o,
    output logic         rneg_o,
    output logic         signed_o,
    output logic         pre_ovf_o
);
    localparam int NW = 2 * W;

    logic [NW-1:0] num, nmag;
    logic          snum, sden;

    always_comb begin
        signed_o = 1'b1;
        num      = {hi_i, lo_i};
        unique case (mode_i)
            MD_S32:  num = {hi_i, lo_i};
            MD_U32:  begin
                         num      = {hi_i, lo_i};
                         signed_o = 1'b0;
                     end
            MD_S16:  num = {{W{lo_i[W-1]}}, lo_i};
            MD_FRAC: num = {lo_i[W-1], lo_i, {(W-1){1'b0}}};
            default: begin
                         num      = {{W{1'b0}}, lo_i};
                         signed_o = 1'b0;
                     end
        endcase
        snum      = signed_o & num[NW-1];
        sden      = signed_o & dsr_i[W-1];
        nmag      = snum ? (~num + 1'b1) : num;
        dmag_o    = sden ? (~dsr_i + 1'b1) : dsr_i;
        mag_hi_o  = nmag[NW-1:W];
        mag_lo_o  = nmag[W-1:0];
        qneg_o    = snum ^ sden;
        rneg_o    = snum;
        pre_ovf_o = (dmag_o == '0) || (mag_hi_o >= dmag_o);
    end

endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dmag_i,
    output logic [W-1:0] rem_o,
    output logic         qbit_o
);
    logic [W:0] trial, diff;

    always_comb begin
        trial  = {rem_i, bit_i};
        diff   = trial - {1'b0, dmag_i};
        qbit_o = (trial >= {1'b0, dmag_i});
        rem_o  = qbit_o ? diff[W-1:0] : trial[W-1:0];
    end

endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
    parameter int W = 16
) (
    input  logic [W-1:0] qmag_i,
    input  logic [W-1:0] rmag_i,
    input  logic         qneg_i,
    input  logic         rneg_i,
    input  logic         signed_i,
    input  logic         pre_ovf_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

    logic range_bad;

    always_comb begin
        if (!signed_i)   range_bad = 1'b0;
        else if (qneg_i) range_bad = (qmag_i > MIN_MAG);
        else             range_bad = qmag_i[W-1];
        ovf_o  = pre_ovf_i | range_bad;
        quot_o = qneg_i ? (~qmag_i + 1'b1) : qmag_i;
        rem_o  = rneg_i ? (~rmag_i + 1'b1) : rmag_i;
    end

endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step_en,
    input  logic [2:0]   mode,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         busy,
    output logic         done,
    output logic         overflow
);
    div_state_e state;
    logic       accept, ext_en, div_en, fix_en;

    // captured operands
    logic [2:0]   mode_q;
    logic [W-1:0] hi_q, lo_q, dsr_q;
    // working state
    logic [W-1:0] rem_q, sh_q, quo_q, dmag_q;
    logic         qneg_q, rneg_q, sgn_q, pre_ovf_q;

    logic [W-1:0] p_mag_hi, p_mag_lo, p_dmag;
    logic         p_qneg, p_rneg, p_sgn, p_pre_ovf;
    logic [W-1:0] s_rem;
    logic         s_qbit;
    logic [W-1:0] f_quot, f_rem;
    logic         f_ovf;

    div_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .step_en_i (step_en),
        .state_o   (state),
        .accept_o  (accept),
        .ext_en_o  (ext_en),
        .div_en_o  (div_en),
        .fix_en_o  (fix_en),
        .busy_o    (busy),
        .done_o    (done)
    );

    div_prep #(.W(W)) u_prep (
        .mode_i    (mode_q),
        .hi_i      (hi_q),
        .lo_i      (lo_q),
        .dsr_i     (dsr_q),
        .mag_hi_o  (p_mag_hi),
        .mag_lo_o  (p_mag_lo),
        .dmag_o    (p_dmag),
        .qneg_o    (p_qneg),
        .rneg_o    (p_rneg),
        .signed_o  (p_sgn),
        .pre_ovf_o (p_pre_ovf)
    );

    div_step #(.W(W)) u_step (
        .rem_i  (rem_q),
        .bit_i  (sh_q[W-1]),
        .dmag_i (dmag_q),
        .rem_o  (s_rem),
        .qbit_o (s_qbit)
    );

    div_fixup #(.W(W)) u_fixup (
        .qmag_i    (quo_q),
        .rmag_i    (rem_q),
        .qneg_i    (qneg_q),
        .rneg_i    (rneg_q),
        .signed_i  (sgn_q),
        .pre_ovf_i (pre_ovf_q),
        .quot_o    (f_quot),
        .rem_o     (f_rem),
        .ovf_o     (f_ovf)
    );

    // operand capture on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            dsr_q  <= '0;
        end else if (accept) begin
            mode_q <= mode;
            hi_q   <= dividend_hi;
            lo_q   <= dividend_lo;
            dsr_q  <= divisor;
        end
    end

    // iteration datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            sh_q      <= '0;
            quo_q     <= '0;
            dmag_q    <= '0;
            qneg_q    <= 1'b0;
            rneg_q    <= 1'b0;
            sgn_q     <= 1'b0;
            pre_ovf_q <= 1'b0;
        end else if (ext_en) begin
            rem_q     <= p_mag_hi;
            sh_q      <= p_mag_lo;
            quo_q     <= '0;
            dmag_q    <= p_dmag;
            qneg_q    <= p_qneg;
            rneg_q    <= p_rneg;
            sgn_q     <= p_sgn;
            pre_ovf_q <= p_pre_ovf;
        end else if (div_en) begin
            rem_q <= s_rem;
            sh_q  <= {sh_q[W-2:0], 1'b0};
            quo_q <= {quo_q[W-2:0], s_qbit};
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            overflow  <= 1'b0;
        end else if (fix_en) begin
            quotient  <= f_quot;
            remainder <= f_rem;
            overflow  <= f_ovf;
        end
    end

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step_en |=> $stable(rem_q) && $stable(quo_q) && $stable(sh_q)); // R7
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE) && !pre_ovf_q |-> rem_q < dmag_q);                 // R5
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        done && (dsr_q == '0) |-> overflow);                                    // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient) && $stable(remainder) && $stable(overflow)); // R12
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(dsr_q) && $stable(lo_q) && $stable(hi_q) && $stable(mode_q)); // R9

endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] dividend_hi = '0;
    logic [15:0] dividend_lo = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quotient, remainder;
    logic        busy, done, overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    iter_divider u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .step_en     (step_en),
        .mode        (mode),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .busy        (busy),
        .done        (done),
        .overflow    (overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [2:0] m, input logic [15:0] h, l, d,
                                    output logic [15:0] q, output logic [15:0] r,
                                    output bit ovf);
        longint n, dv, qq, rr;
        bit sg;
        case (m)
            3'd0: begin n = longint'($signed({h, l})); dv = longint'($signed(d)); sg = 1'b1; end
            3'd1: begin n = longint'({h, l});          dv = longint'(d);          sg = 1'b0; end
            3'd2: begin n = longint'($signed(l));      dv = longint'($signed(d)); sg = 1'b1; end
            3'd4: begin n = longint'($signed(l)) * 32768; dv = longint'($signed(d)); sg = 1'b1; end
            default: begin n = longint'(l);            dv = longint'(d);          sg = 1'b0; end
        endcase
        if (dv == 0) begin
            q = '0; r = '0; ovf = 1'b1;
            return;
        end
        qq  = n / dv;
        rr  = n % dv;
        ovf = sg ? (qq > 32767 || qq < -32768) : (qq > 65535);
        q   = qq[15:0];
        r   = rr[15:0];
    endfunction

    function automatic string qtag(input logic [2:0] m);
        case (m)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd4:    return "R4";
            default: return "R3";
        endcase
    endfunction

    // one divide; entered and left at a negative clock edge
    task automatic run_op(input logic [2:0] m, input logic [15:0] h, l, d,
                          input int pause_pct, input bit poke);
        logic [15:0] eq, er, q0, r0;
        bit eo, o0, poked;
        int steps, guard, busy_err;
        steps = 0; guard = 0; busy_err = 0; poked = 1'b0;
        ref_div(m, h, l, d, eq, er, eo);
        @(negedge clk);
        start = 1'b1; mode = m; dividend_hi = h; dividend_lo = l; divisor = d;
        step_en = 1'($urandom_range(1));
        @(negedge clk);
        start = 1'b0;
        mode = 3'($urandom_range(4)); dividend_hi = 16'($urandom);
        dividend_lo = 16'($urandom);  divisor = 16'($urandom);
        forever begin
            if (done) break;
            if (!busy) busy_err++;
            start = (poke && steps == 5 && !poked);
            if (start) poked = 1'b1;
            step_en = (int'($urandom_range(99)) >= pause_pct);
            @(posedge clk);
            if (step_en) steps++;
            @(negedge clk);
            guard++;
            if (guard > 3000) break;
        end
        start = 1'b0;
        check(busy_err == 0, "R8", "busy dropped before done", busy_err, 0);
        check(busy == 1'b0, "R8", "busy during done", busy, 0);
        if (pause_pct == 0)
            check(steps == 18, "R6", "edges to done", steps, 18);
        else
            check(steps == 18, "R7", "enabled edges to done", steps, 18);
        check(overflow == eo, (d == 16'h0) ? "R10" : "R11", "overflow", overflow, eo);
        if (!eo) begin
            check(quotient == eq, poke ? "R9" : qtag(m), "quotient", quotient, eq);
            check(remainder == er, "R5", "remainder", remainder, er);
        end
        q0 = quotient; r0 = remainder; o0 = overflow;
        step_en = 1'($urandom_range(1));
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", done, 0);
        check(quotient == q0 && remainder == r0 && overflow == o0, "R12",
              "results after done", {quotient, remainder}, {q0, r0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] qh;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        check(quotient == 0 && remainder == 0, "R12", "reset results", {quotient, remainder}, 0);
        check(busy == 0 && done == 0 && overflow == 0, "R12", "reset flags",
              {busy, done, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op(3'd0, 16'h8000, 16'h0000, 16'hFFFF, 0, 0);  // R11: most negative / -1
        run_op(3'd2, 16'h1234, 16'h8000, 16'hFFFF, 0, 0);  // R11 16-bit version
        run_op(3'd2, 16'hFFFF, 16'h8001, 16'hFFFF, 0, 0);  // R3 -> 32767
        run_op(3'd0, 16'h0000, 16'h0000, 16'h0005, 0, 0);  // zero dividend
        run_op(3'd0, 16'hFFFF, 16'hFFF9, 16'h0002, 0, 0);  // R5 negative remainder
        run_op(3'd0, 16'hFFFE, 16'h8000, 16'h0003, 0, 0);  // quotient -32768 fits
        run_op(3'd0, 16'h0001, 16'h8000, 16'h0003, 0, 0);  // quotient 32768 overflows
        run_op(3'd1, 16'h0005, 16'h0000, 16'h0005, 0, 0);  // R11 unsigned high word >= divisor
        run_op(3'd1, 16'h0004, 16'hFFFF, 16'h0005, 0, 0);  // R2 near limit
        run_op(3'd3, 16'hABCD, 16'h1234, 16'h0000, 0, 0);  // R10
        run_op(3'd0, 16'h0000, 16'h7FFF, 16'h0001, 0, 0);  // divisor +1
        run_op(3'd3, 16'hFFFF, 16'hFFFF, 16'h0001, 0, 0);  // R3 zero-extend, divisor 1
        run_op(3'd6, 16'h5555, 16'hFFFF, 16'h0010, 0, 0);  // R3 code 6 as code 3
        run_op(3'd4, 16'h0000, 16'h4000, 16'h8000, 0, 0);  // R4 0.5 / -1
        run_op(3'd4, 16'h0000, 16'h2000, 16'h4000, 0, 0);  // R4 0.25 / 0.5
        run_op(3'd4, 16'h0000, 16'h8000, 16'h8000, 0, 0);  // R11 -1 / -1
        run_op(3'd4, 16'h0000, 16'hC000, 16'h6000, 30, 0); // R4 with pauses

        // duplicate start mid-operation
        run_op(3'd0, 16'hFFF0, 16'h1234, 16'h0777, 40, 1); // R9
        run_op(3'd1, 16'h0100, 16'h0F0F, 16'h4321, 0, 1);  // R9

        // hold after completion with inputs moving
        qh = quotient;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dividend_lo = 16'($urandom); step_en = 1'($urandom_range(1));
        end
        check(quotient == qh && done == 0, "R12", "idle hold", quotient, qh);

        // constrained random
        for (int i = 0; i < 220; i++) begin
            logic [2:0]  m;
            logic [15:0] h, l, d;
            int          pp;
            m = 3'($urandom_range(4));
            l = 16'($urandom);
            d = 16'($urandom);
            h = 16'($urandom);
            if (m <= 3'd1 && $urandom_range(1) == 1) begin
                // keep the quotient in range half of the time
                if (m == 3'd1) begin
                    if (d == 0) d = 16'd1;
                    h = 16'($urandom_range(int'(d) - 1));
                end else begin
                    h = {16{l[15]}} ^ 16'($urandom_range(3));
                end
            end
            if ($urandom_range(7) == 0) d = 16'hFFFF;
            pp = (i % 3 == 0) ? 0 : ((i % 3 == 1) ? 30 : 70);
            run_op(m, h, l, d, pp, (i % 17 == 5));
        end

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule